// File: doc/BRIEF.md
# GPIO Bank with Pin Interrupts

This block is a single bank of general-purpose pins (32 by default) controlled through a small word-addressed register port. Software writes one bit per pin into an output-data word and an output-enable word to drive the pads. Software reads a synchronized copy of the pad inputs. A pad control word selects whether each pin's pull resistor is on and which way it pulls. Three bit-sliced words hold a 3-bit drive-strength code for every pin. These control words are presented as plain register outputs toward the pad ring.

Every pin can raise an interrupt. Three independent control bits choose its sense: level against edge, single against both edges, and polarity. Edge events are latched in a raw status word until software acknowledges them by writing ones to a clear word. Level events track the pin and cannot be acknowledged away. A mask word gates raw status into a masked status word. The OR of the masked bits leaves the block as one registered interrupt line.

Register writes take effect on the clock edge at which `reg_we` is sampled high. Reads are combinational from `reg_addr`.

Top module: `pio_bank`

## Requirements
- R1: After reset every register reads 0 and the outputs `pin_out`, `pin_oe`, `pull_en`, `pull_up`, `drv_code` and `irq` are all 0. So every pin starts as an input, with its interrupt masked and its pull off.
- R2: Word 1 holds the output data and word 2 holds the output enable. Bit n of each controls pin n. A write appears on `pin_out` / `pin_oe` at the clock edge that takes it, and the same word reads back.
- R3: Word 0 returns the pin inputs through a two-flop synchronizer. A change on `pin_in` shows in word 0 after exactly two rising clock edges, and not after one.
- R4: Word 3 bit n = 0 puts pin n in edge mode. In edge mode, with word 4 bit n = 0, the polarity word 5 bit n selects the edge: 1 for rising, 0 for falling. A detected edge sets raw status (word 7) bit n at the third rising edge after the pin changes. The bit then stays set until it is cleared.
- R5: In edge mode, word 4 bit n = 1 makes pin n fire on both edges, whatever its polarity bit.
- R6: Word 3 bit n = 1 puts pin n in level mode. Raw status bit n then follows the synchronized level, active high when polarity is 1 and active low when it is 0. A clear cannot remove the bit while the level holds, and the bit drops when the level goes away.
- R7: Writing 1 to bit n of word 9 clears the latched edge status of pin n at that edge. Bits written as 0 have no effect, and word 9 always reads 0. If a new edge is detected in the same cycle as the clear, the bit stays set.
- R8: Word 6 is the mask, where 1 enables the pin. Word 8 reads raw status AND mask.
- R9: `irq` is the OR of all masked status bits, delayed by one clock register.
- R10: Word 14 (pull enable) drives `pull_en`, and word 13 (pull select, 1 = up, 0 = down) drives `pull_up`. Both read back.
- R11: Words 22, 23 and 24 hold drive-strength bits 0, 1 and 2. Bit n of word 22+i is bit i of pin n's code, and the code is presented as `drv_code[3n+2:3n]`. The code equals milliamps/2 − 1, so 2 mA is 0 and 16 mA is 7.
- R12: Writes to words 0, 7 and 8 and to unmapped words change nothing. Unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output data |
| pin_oe | output | 32 | Pad output enables |
| pull_en | output | 32 | Pull resistor enables |
| pull_up | output | 32 | Pull direction, 1 = up |
| drv_code | output | 96 | Drive-strength codes, 3 bits per pin |
| irq | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach from the ports is a clear and a freshly synchronized edge landing in the same clock. The clear is a single-cycle write, but the edge only exists inside the synchronizer pipeline. The bench therefore changes a dual-edge pin, counts exactly two edges, and issues the clear so that it is taken on the third edge. Level-mode immunity to clears, and switching the polarity of a level pin while the pin is held, are also driven directly. Long random runs of pin toggles, sense changes, mask changes and clears are then compared against a cycle model kept in the bench.

// File: rtl/pio_bank_pkg.sv
`timescale 1ns/1ps
package pio_bank_pkg;

   // register word map; the bench and software rely on these positions
   localparam int unsigned W_DIN  = 0;
   localparam int unsigned W_MST  = 8;
   localparam int unsigned W_RAW  = 7;
   localparam int unsigned W_CLR  = 9;
   localparam int unsigned W_DRV0 = 22;

   // writable per-pin configuration words, indexed by CI_*
   localparam int unsigned CFG_N = 8;
   localparam int unsigned CI_DOUT = 0;
   localparam int unsigned CI_OE   = 1;
   localparam int unsigned CI_LVL  = 2;
   localparam int unsigned CI_BOTH = 3;
   localparam int unsigned CI_POL  = 4;
   localparam int unsigned CI_MASK = 5;
   localparam int unsigned CI_PSEL = 6;
   localparam int unsigned CI_PEN  = 7;
   localparam int unsigned CFG_WORD [CFG_N] = '{1, 2, 3, 4, 5, 6, 13, 14};

   typedef enum logic [2:0] {
      SENSE_FALL = 3'd0,
      SENSE_RISE = 3'd1,
      SENSE_BOTH = 3'd2,
      SENSE_LOW  = 3'd3,
      SENSE_HIGH = 3'd4
   } sense_e;

   function automatic sense_e pick_sense(input logic lvl, input logic both,
                                         input logic pol);
      if (lvl)  return pol ? SENSE_HIGH : SENSE_LOW;
      if (both) return SENSE_BOTH;
      return pol ? SENSE_RISE : SENSE_FALL;
   endfunction

endpackage

// File: rtl/pio_sync.sv
`timescale 1ns/1ps
module pio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out,
   output logic [WIDTH-1:0] last_out
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain_q[s] <= chain_q[s-1];
         end
         last_q <= chain_q[STAGES-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
   assign last_out = last_q;

endmodule

// File: rtl/pio_irq_cell.sv
`timescale 1ns/1ps
module pio_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_mode,
   input  logic both_edges,
   input  logic polarity,
   input  logic cur,
   input  logic last,
   input  logic clr,
   output logic stat
);
   import pio_bank_pkg::*;

   sense_e sense;
   logic   hit;

   assign sense = pick_sense(lvl_mode, both_edges, polarity);

   always_comb begin
      unique case (sense)
         SENSE_HIGH: hit = cur;
         SENSE_LOW:  hit = ~cur;
         SENSE_BOTH: hit = cur ^ last;
         SENSE_RISE: hit = cur & ~last;
         SENSE_FALL: hit = ~cur & last;
         default:    hit = 1'b0;
      endcase
   end

   // level: status tracks hit; edge: sticky, a new hit beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stat <= 1'b0;
      else if (lvl_mode) stat <= hit;
      else               stat <= hit | (stat & ~clr);
   end

endmodule

// File: rtl/pio_regfile.sv
`timescale 1ns/1ps
module pio_regfile #(
   parameter int unsigned NPIN     = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DRV_BITS = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [NPIN-1:0]                wdata,
   input  logic [NPIN-1:0]                din_vec,
   input  logic [NPIN-1:0]                raw_vec,
   output logic [pio_bank_pkg::CFG_N-1:0][NPIN-1:0] cfg_vec,
   output logic [DRV_BITS-1:0][NPIN-1:0]  drv_slice,
   output logic [NPIN-1:0]                clr_vec,
   output logic [NPIN-1:0]                rdata
);
   import pio_bank_pkg::*;

   localparam logic [ADDR_W-1:0] A_DIN = ADDR_W'(W_DIN);
   localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(W_RAW);
   localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(W_MST);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(W_CLR);

   for (genvar c = 0; c < int'(CFG_N); c++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_WORD[c]);
      logic [NPIN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q <= '0;
         else if (we && addr == MY_ADDR)  q <= wdata;
      end
      assign cfg_vec[c] = q;
   end

   for (genvar b = 0; b < int'(DRV_BITS); b++) begin : g_drv
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(W_DRV0 + b);
      logic [NPIN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      q <= '0;
         else if (we && addr == MY_ADDR)  q <= wdata;
      end
      assign drv_slice[b] = q;
   end

   assign clr_vec = (we && addr == A_CLR) ? wdata : '0;

   always_comb begin
      rdata = '0;
      if (addr == A_DIN) rdata = din_vec;
      if (addr == A_RAW) rdata = raw_vec;
      if (addr == A_MST) rdata = raw_vec & cfg_vec[CI_MASK];
      for (int c = 0; c < int'(CFG_N); c++) begin
         if (addr == ADDR_W'(CFG_WORD[c])) rdata = cfg_vec[c];
      end
      for (int b = 0; b < int'(DRV_BITS); b++) begin
         if (addr == ADDR_W'(W_DRV0 + b)) rdata = drv_slice[b];
      end
   end

endmodule

// File: rtl/pio_bank.sv
`timescale 1ns/1ps
module pio_bank #(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DRV_BITS    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [NPIN-1:0]          reg_wdata,
   output logic [NPIN-1:0]          reg_rdata,
   input  logic [NPIN-1:0]          pin_in,
   output logic [NPIN-1:0]          pin_out,
   output logic [NPIN-1:0]          pin_oe,
   output logic [NPIN-1:0]          pull_en,
   output logic [NPIN-1:0]          pull_up,
   output logic [NPIN*DRV_BITS-1:0] drv_code,
   output logic                     irq
);
   import pio_bank_pkg::*;

   localparam int unsigned MAX_WORD = (1 << ADDR_W) - 1;

   initial begin
      assert (NPIN >= 1 && NPIN <= 32)
         else $fatal(1, "pio_bank: NPIN must be 1..32");
      assert (SYNC_STAGES >= 2)
         else $fatal(1, "pio_bank: SYNC_STAGES must be at least 2");
      assert (DRV_BITS >= 1 && W_DRV0 + DRV_BITS - 1 <= MAX_WORD)
         else $fatal(1, "pio_bank: drive slices do not fit the address space");
   end

   logic [NPIN-1:0]                 sync_vec;
   logic [NPIN-1:0]                 last_vec;
   logic [NPIN-1:0]                 raw_stat;
   logic [NPIN-1:0]                 clr_vec;
   logic [CFG_N-1:0][NPIN-1:0]      cfg_vec;
   logic [DRV_BITS-1:0][NPIN-1:0]   drv_slice;
   logic [NPIN-1:0]                 mask_vec;
   logic [NPIN-1:0]                 lvl_vec;
   logic                            irq_q;

   pio_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (sync_vec),
      .last_out (last_vec)
   );

   pio_regfile #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DRV_BITS(DRV_BITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .din_vec   (sync_vec),
      .raw_vec   (raw_stat),
      .cfg_vec   (cfg_vec),
      .drv_slice (drv_slice),
      .clr_vec   (clr_vec),
      .rdata     (reg_rdata)
   );

   assign pin_out  = cfg_vec[CI_DOUT];
   assign pin_oe   = cfg_vec[CI_OE];
   assign pull_en  = cfg_vec[CI_PEN];
   assign pull_up  = cfg_vec[CI_PSEL];
   assign mask_vec = cfg_vec[CI_MASK];
   assign lvl_vec  = cfg_vec[CI_LVL];

   for (genvar n = 0; n < int'(NPIN); n++) begin : g_pin
      pio_irq_cell u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .lvl_mode   (cfg_vec[CI_LVL][n]),
         .both_edges (cfg_vec[CI_BOTH][n]),
         .polarity   (cfg_vec[CI_POL][n]),
         .cur        (sync_vec[n]),
         .last       (last_vec[n]),
         .clr        (clr_vec[n]),
         .stat       (raw_stat[n])
      );
      for (genvar b = 0; b < int'(DRV_BITS); b++) begin : g_bit
         assign drv_code[n*DRV_BITS + b] = drv_slice[b][n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(raw_stat & mask_vec);
   end

   assign irq = irq_q;

endmodule

// File: rtl/pio_bank_chk.sv
`timescale 1ns/1ps
module pio_bank_chk #(
   parameter int unsigned NPIN     = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned DRV_BITS = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_we,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [NPIN-1:0]          reg_wdata,
   input logic [NPIN-1:0]          reg_rdata,
   input logic [NPIN-1:0]          pin_out,
   input logic [NPIN-1:0]          pin_oe,
   input logic [NPIN-1:0]          pull_en,
   input logic [NPIN-1:0]          pull_up,
   input logic [NPIN*DRV_BITS-1:0] drv_code,
   input logic                     irq,
   input logic [NPIN-1:0]          raw_stat,
   input logic [NPIN-1:0]          mask_vec,
   input logic [NPIN-1:0]          lvl_vec
);
   import pio_bank_pkg::*;

   localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(W_DIN);
   localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(W_RAW);
   localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(W_MST);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(W_CLR);
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(CFG_WORD[CI_DOUT]);
   localparam logic [ADDR_W-1:0] A_PEN  = ADDR_W'(CFG_WORD[CI_PEN]);

   logic [NPIN-1:0] clr_seen;
   logic            ro_write;
   assign clr_seen = (reg_we && reg_addr == A_CLR) ? reg_wdata : '0;
   assign ro_write = reg_we && (reg_addr == A_DIN || reg_addr == A_RAW ||
                                reg_addr == A_MST);

   // R9
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == $past(|(raw_stat & mask_vec)));

   // R8
   mstat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_MST) |-> (reg_rdata == (raw_stat & mask_vec)));

   // R7
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == A_CLR) |-> (reg_rdata == '0));

   // R7
   edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(raw_stat) & ~$past(lvl_vec) & ~$past(clr_seen)) & ~raw_stat) == '0);

   // R2
   dout_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_DOUT) |=> (pin_out == $past(reg_wdata)));

   // R10
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_PEN) |=> (pull_en == $past(reg_wdata)));

   // R12
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ro_write |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pull_en) &&
                    $stable(pull_up) && $stable(drv_code) && $stable(mask_vec) &&
                    $stable(lvl_vec)));

endmodule

bind pio_bank pio_bank_chk #(
   .NPIN(NPIN), .ADDR_W(ADDR_W), .DRV_BITS(DRV_BITS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pull_en   (pull_en),
   .pull_up   (pull_up),
   .drv_code  (drv_code),
   .irq       (irq),
   .raw_stat  (raw_stat),
   .mask_vec  (mask_vec),
   .lvl_vec   (lvl_vec)
);

// File: tb/pio_bank_tb_top.sv
`timescale 1ns/1ps
module pio_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe, pull_en, pull_up;
   logic [95:0] drv_code;
   logic        irq;

   always #2 clk = ~clk;

   pio_bank dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
      .pull_up(pull_up), .drv_code(drv_code), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // bench-side expectation state
   logic [31:0] m_dout, m_oe, m_lvl, m_both, m_pol, m_mask, m_psel, m_pen;
   logic [31:0] m_drv [3];
   logic [31:0] m_s1, m_s2, m_prev, m_raw;
   logic        m_irq;
   logic [31:0] m_clr;

   function automatic logic [31:0] next_raw(input logic [31:0] s, input logic [31:0] p,
                                            input logic [31:0] raw, input logic [31:0] clr,
                                            input logic [31:0] lvl, input logic [31:0] both,
                                            input logic [31:0] pol);
      logic [31:0] r;
      for (int n = 0; n < 32; n++) begin
         logic hit;
         if (lvl[n])       hit = (s[n] == pol[n]);
         else if (both[n]) hit = s[n] ^ p[n];
         else if (pol[n])  hit = s[n] & ~p[n];
         else              hit = ~s[n] & p[n];
         r[n] = lvl[n] ? hit : (hit | (raw[n] & ~clr[n]));
      end
      return r;
   endfunction

   always @(posedge clk) begin
      m_clr = (we && addr == 5'd9) ? wdata : 32'h0;
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0; m_irq <= 1'b0;
      end else begin
         m_s1   <= pin_in;
         m_s2   <= m_s1;
         m_prev <= m_s2;
         m_raw  <= next_raw(m_s2, m_prev, m_raw, m_clr, m_lvl, m_both, m_pol);
         m_irq  <= |(m_raw & m_mask);
      end
   end

   task automatic check(input string tag, input logic [95:0] got, input logic [95:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      we = 1'b1; addr = a[4:0]; wdata = d;
      @(negedge clk);
      we = 1'b0;
      case (a)
         1:  m_dout = d;   2:  m_oe = d;    3:  m_lvl = d;   4:  m_both = d;
         5:  m_pol = d;    6:  m_mask = d;  13: m_psel = d;  14: m_pen = d;
         22: m_drv[0] = d; 23: m_drv[1] = d; 24: m_drv[2] = d;
         default: ;
      endcase
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = a[4:0];
      #1;
      d = rdata;
   endtask

   task automatic compare_all();
      logic [31:0] v;
      rd(0, v); check("R3 data-in vs model", v, m_s2);
      rd(7, v); check("R4/R5/R6 raw status vs model", v, m_raw);
      rd(8, v); check("R8 masked status vs model", v, m_raw & m_mask);
      rd(3, v); check("R6 sense word readback", v, m_lvl);
      check("R9 irq vs model", irq, m_irq);
      check("R2 pin_out vs model", pin_out, m_dout);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      m_dout = '0; m_oe = '0; m_lvl = '0; m_both = '0; m_pol = '0;
      m_mask = '0; m_psel = '0; m_pen = '0;
      for (int i = 0; i < 3; i++) m_drv[i] = '0;
      void'($urandom(32'h1F2E3D4C));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      for (int a = 0; a < 32; a++) begin
         rd(a, v); check("R1 reset register", v, 0);
      end
      check("R1 reset pin_out", pin_out, 0);
      check("R1 reset pin_oe", pin_oe, 0);
      check("R1 reset pull_en", pull_en, 0);
      check("R1 reset pull_up", pull_up, 0);
      check("R1 reset drv_code", drv_code, 0);
      check("R1 reset irq", irq, 0);

      // R2 output data and enable
      wr(1, 32'hA5A5_0F0F);
      check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
      rd(1, v); check("R2 dout readback", v, 32'hA5A5_0F0F);
      wr(2, 32'h0000_FFFF);
      check("R2 pin_oe", pin_oe, 32'h0000_FFFF);

      // R10 pulls
      wr(14, 32'h0000_00F0);
      wr(13, 32'h0000_0030);
      check("R10 pull_en", pull_en, 32'h0000_00F0);
      check("R10 pull_up", pull_up, 32'h0000_0030);
      rd(13, v); check("R10 pull select readback", v, 32'h0000_0030);

      // R11 drive strength: pin5 8 mA (3), pin31 16 mA (7), pin0 2 mA (0)
      wr(22, 32'h8000_0020);
      wr(23, 32'h8000_0020);
      wr(24, 32'h8000_0000);
      check("R11 pin5 code", drv_code[5*3 +: 3], 3'd3);
      check("R11 pin31 code", drv_code[31*3 +: 3], 3'd7);
      check("R11 pin0 code", drv_code[0 +: 3], 3'd0);
      rd(24, v); check("R11 slice2 readback", v, 32'h8000_0000);

      // R12 read-only and unmapped words
      wr(0, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF);
      wr(31, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF);
      rd(31, v); check("R12 unmapped 31 reads zero", v, 0);
      rd(11, v); check("R12 unmapped 11 reads zero", v, 0);
      rd(7, v);  check("R12 raw unchanged", v, 0);
      rd(0, v);  check("R12 data-in unchanged", v, 0);
      check("R12 pin_out unchanged", pin_out, 32'hA5A5_0F0F);
      check("R12 pin_oe unchanged", pin_oe, 32'h0000_FFFF);
      check("R12 drv_code unchanged", drv_code[5*3 +: 3], 3'd3);

      // R3 synchronizer latency
      pin_in[0] = 1'b1;
      tick(1); rd(0, v); check("R3 data-in after one edge", v[0], 1'b0);
      tick(1); rd(0, v); check("R3 data-in after two edges", v[0], 1'b1);

      // R4 default falling edge: rising must not fire
      tick(1); rd(7, v); check("R4 rise ignored in falling mode", v, 0);
      pin_in[0] = 1'b0;
      tick(2); rd(7, v); check("R4 fall not yet latched", v, 0);
      tick(1); rd(7, v); check("R4 fall latched third edge", v, 32'h1);
      tick(5); rd(7, v); check("R4 status held", v, 32'h1);

      // R4 rising on pin1
      wr(5, 32'h2);
      pin_in[1] = 1'b1;
      tick(3); rd(7, v); check("R4 rising edge pin1", v, 32'h3);

      // R7 clear
      wr(9, 32'h1);
      rd(7, v); check("R7 clear pin0", v, 32'h2);
      rd(9, v); check("R7 clear word reads zero", v, 0);
      wr(9, 32'h0);
      rd(7, v); check("R7 zero bits no effect", v, 32'h2);

      // R8, R9 mask and irq timing
      wr(6, 32'h2);
      rd(8, v); check("R8 masked status", v, 32'h2);
      check("R9 irq one cycle later, not yet", irq, 1'b0);
      tick(1); check("R9 irq asserted", irq, 1'b1);
      wr(6, 32'h0);
      rd(8, v); check("R8 masked status zero", v, 0);
      check("R9 irq still from previous mask", irq, 1'b1);
      tick(1); check("R9 irq dropped", irq, 1'b0);

      // R5 both edges on pin2 with polarity 0
      wr(4, 32'h4);
      pin_in[2] = 1'b1;
      tick(3); rd(7, v); check("R5 dual rising", v & 32'h4, 32'h4);
      wr(9, 32'h4);
      rd(7, v); check("R7 clear pin2", v & 32'h4, 32'h0);
      pin_in[2] = 1'b0;
      tick(3); rd(7, v); check("R5 dual falling", v & 32'h4, 32'h4);

      // R6 level high on pin3
      wr(5, 32'hA);
      wr(3, 32'h8);
      pin_in[3] = 1'b1;
      tick(3); rd(7, v); check("R6 level high set", v & 32'h8, 32'h8);
      wr(9, 32'h8);
      rd(7, v); check("R6 clear ignored while asserted", v & 32'h8, 32'h8);
      pin_in[3] = 1'b0;
      tick(2); rd(7, v); check("R6 level still seen", v & 32'h8, 32'h8);
      tick(1); rd(7, v); check("R6 level drop", v & 32'h8, 32'h0);
      wr(5, 32'h2);
      tick(1); rd(7, v); check("R6 active-low level", v & 32'h8, 32'h8);
      wr(3, 32'h0);
      wr(9, 32'h8);

      // R7 clear and new edge in the same cycle on dual-edge pin4
      wr(4, 32'h14);
      pin_in[4] = 1'b1;
      tick(3); rd(7, v); check("R7 pin4 first edge", v & 32'h10, 32'h10);
      pin_in[4] = 1'b0;
      tick(2);
      wr(9, 32'h10);
      rd(7, v); check("R7 new edge beats clear", v & 32'h10, 32'h10);
      wr(9, 32'h10);
      rd(7, v); check("R7 later clear works", v & 32'h10, 32'h0);

      compare_all();

      // random phase against the bench model
      for (int it = 0; it < 1500; it++) begin
         int unsigned k;
         k = $urandom_range(0, 9);
         case (k)
            0, 1, 2, 3: pin_in = pin_in ^ ($urandom & $urandom & $urandom);
            4: wr(3, $urandom & $urandom);
            5: wr(4, $urandom);
            6: wr(5, $urandom);
            7: wr(6, $urandom);
            8: wr(9, $urandom);
            default: wr(1, $urandom);
         endcase
         tick($urandom_range(0, 2));
         compare_all();
      end

      done = 1;
      summary();
      $finish;
   end

endmodule